// File: doc/BRIEF.md
# Output-Stationary Multiply-Accumulate Array

A one-dimensional chain of processing elements in which every element owns one output position and keeps its running partial sum in a local register until the whole accumulation is finished. Each compute step broadcasts one signed weight to all elements in the same cycle. An input value enters at one end of the chain and moves one element further on each step. As a result, element `i` multiplies the weight by the input that was injected `i` steps earlier, and neighbouring elements produce neighbouring output positions.

A job begins with a start pulse that carries the accumulation length K. The host then presents K valid steps, each with a weight and an input value. After the K-th step the array raises its done flag and empties its sums one per handshake through the accumulator registers themselves, which act as a shift chain with element 0 at the head. Fully connected rows and small convolution tiles map onto this by choosing the order of weights and inputs.

Top module: `osmac_array`

## Requirements
- R1: After reset `out_valid` and `done` are 0.
- R2: A cycle with `start` high clears every accumulator and every relayed input to zero and latches `len_k` as K. A start arriving while the array is accumulating or draining abandons the job in progress.
- R3: Steps are numbered t = 0 .. K-1 from the start. On accepted step t, element i adds `step_weight`(t) × x(t−i) to its sum, where x(n) is the `step_act` value of step n and x(n) = 0 for n < 0. Weights and inputs are signed two's complement 8-bit values.
- R4: A cycle with `step_valid` low changes no sum and no relayed input.
- R5: `done` and `out_valid` rise in the cycle after the K-th accepted step. From then until the next start, `step_valid` is ignored.
- R6: Draining delivers element 0's sum first, then elements 1, 2, … in order, one per cycle in which `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_data` and `out_valid` hold.
- R7: After P accepted outputs, `out_valid` and `done` fall and the array is idle.
- R8: Sums are signed 24-bit and wrap modulo 2^24 on overflow.
- R9: A start with K = 0 raises `done` in the next cycle and drains P zeros.
- R10: A start during draining discards the remaining sums. `out_valid` is 0 in the next cycle, and the new job's results are the only ones delivered afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; clears the sums and latches `len_k` |
| len_k | input | KW | Accumulation length K, sampled on `start` |
| step_valid | input | 1 | Marks a compute step |
| step_weight | input | 8 | Signed weight, broadcast to all elements |
| step_act | input | 8 | Signed input value, injected at element 0 |
| out_valid | output | 1 | A finished sum is present on `out_data` |
| out_ready | input | 1 | Consumer accepts `out_data` |
| out_data | output | 24 | Signed sum at the head of the drain chain |
| done | output | 1 | Accumulation finished; high for the whole drain |

## Verification
Assertions inside the array check, on every cycle, the local rules of each element and of the sequencer. A start zeroes the state. An element changes nothing without an enable. A relayed input and a shifted sum equal the neighbour's value from the cycle before. The step counter never passes K. The array leaves the drain after exactly P pops, and the head output holds under back-pressure. Only the bench scenarios can show that the products land in the correct element with the correct input alignment, that wrap-around matches 24-bit arithmetic, and that an aborted drain leaves no stale sum behind. The bench computes every expected sum independently and compares it against each delivered result, with idle gaps and random back-pressure applied.

// File: rtl/osmac_pkg.sv
package osmac_pkg;
  localparam int DATA_W = 8;
  localparam int ACC_W  = 24;

  typedef logic signed [DATA_W-1:0] data_t;
  typedef logic signed [ACC_W-1:0]  acc_t;
  typedef logic signed [2*DATA_W-1:0] prod_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ACCUM = 2'd1,
    PH_DRAIN = 2'd2
  } phase_e;

  // One multiply-accumulate, wrapping at ACC_W bits.
  function automatic acc_t mac_step(acc_t acc, data_t w, data_t x);
    prod_t p;
    p = w * x;
    return acc + acc_t'(p);
  endfunction
endpackage

// File: rtl/osmac_ctrl.sv
module osmac_ctrl
  import osmac_pkg::*;
#(
  parameter int P  = 4,
  parameter int KW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] len_k,
  input  logic          step_valid,
  input  logic          out_ready,
  output logic          clr,
  output logic          mac_en,
  output logic          shift_en,
  output logic          done
);
  localparam int DCW = (P > 1) ? $clog2(P) : 1;

  phase_e        phase;
  logic [KW-1:0] k_q;
  logic [KW-1:0] step_cnt;
  logic [DCW-1:0] pop_cnt;
  logic          last_step;
  logic          last_pop;

  assign last_step = (step_cnt == k_q - KW'(1));
  assign last_pop  = (pop_cnt == DCW'(P - 1));

  assign clr      = start;
  assign mac_en   = (phase == PH_ACCUM) && step_valid && !start;
  assign shift_en = (phase == PH_DRAIN) && out_ready && !start;
  assign done     = (phase == PH_DRAIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      k_q      <= '0;
      step_cnt <= '0;
      pop_cnt  <= '0;
    end else if (start) begin
      k_q      <= len_k;
      step_cnt <= '0;
      pop_cnt  <= '0;
      phase    <= (len_k == '0) ? PH_DRAIN : PH_ACCUM;
    end else begin
      case (phase)
        PH_ACCUM: if (mac_en) begin
          step_cnt <= step_cnt + KW'(1);
          if (last_step) phase <= PH_DRAIN;
        end
        PH_DRAIN: if (shift_en) begin
          pop_cnt <= pop_cnt + DCW'(1);
          if (last_pop) phase <= PH_IDLE;
        end
        default: ;
      endcase
    end
  end

  a_r5_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACCUM) |-> (step_cnt < k_q));

  a_r5_done_after_k: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_en && last_step) |=> done);

  a_r7_idle_after_p: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && last_pop) |=> (!done && phase == PH_IDLE));

  a_r9_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len_k == '0) |=> done);

  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len_k != '0) |=> (phase == PH_ACCUM));
endmodule

// File: rtl/osmac_pe.sv
module osmac_pe
  import osmac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  mac_en,
  input  logic  shift_en,
  input  data_t weight,
  input  data_t act_in,
  input  acc_t  acc_in,
  output data_t act_q,
  output acc_t  acc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      act_q <= '0;
      acc_q <= '0;
    end else if (mac_en) begin
      act_q <= act_in;
      acc_q <= mac_step(acc_q, weight, act_in);
    end else if (shift_en) begin
      acc_q <= acc_in;
    end
  end

  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0 && act_q == '0));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !mac_en && !shift_en) |=> ($stable(acc_q) && $stable(act_q)));

  a_r3_relay: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_en && !clr) |=> (act_q == $past(act_in)));

  a_r6_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !mac_en && !clr) |=> (acc_q == $past(acc_in)));
endmodule

// File: rtl/osmac_array.sv
module osmac_array
  import osmac_pkg::*;
#(
  parameter int P  = 4,
  parameter int KW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [KW-1:0]           len_k,
  input  logic                    step_valid,
  input  logic signed [DATA_W-1:0] step_weight,
  input  logic signed [DATA_W-1:0] step_act,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [ACC_W-1:0] out_data,
  output logic                    done
);
  logic clr, mac_en, shift_en, drain_phase;

  data_t act_r [P];
  acc_t  acc_r [P];

  osmac_ctrl #(.P(P), .KW(KW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .len_k      (len_k),
    .step_valid (step_valid),
    .out_ready  (out_ready),
    .clr        (clr),
    .mac_en     (mac_en),
    .shift_en   (shift_en),
    .done       (drain_phase)
  );

  for (genvar i = 0; i < P; i++) begin : g_pe
    data_t a_in;
    acc_t  s_in;
    if (i == 0) begin : g_head
      assign a_in = step_act;
    end else begin : g_body
      assign a_in = act_r[i-1];
    end
    if (i == P - 1) begin : g_tail
      assign s_in = '0;
    end else begin : g_link
      assign s_in = acc_r[i+1];
    end
    osmac_pe u_pe (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .mac_en   (mac_en),
      .shift_en (shift_en),
      .weight   (step_weight),
      .act_in   (a_in),
      .acc_in   (s_in),
      .act_q    (act_r[i]),
      .acc_q    (acc_r[i])
    );
  end

  assign out_valid = drain_phase;
  assign done      = drain_phase;
  assign out_data  = acc_r[0];

  a_r6_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data)));

  a_r10_drop_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len_k != '0) |=> !out_valid);
endmodule

// File: tb/tb_osmac_array.sv
module tb_osmac_array;
  localparam int P  = 4;
  localparam int KW = 16;

  typedef struct {
    logic [23:0] v;
    string       tag;
  } exp_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [KW-1:0] len_k = '0;
  logic        step_valid = 0;
  logic signed [7:0] step_weight = '0;
  logic signed [7:0] step_act = '0;
  logic        out_valid;
  logic        out_ready = 0;
  logic signed [23:0] out_data;
  logic        done;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  hold_ready = 1;
  bit  finished = 0;
  exp_t sb[$];

  always #4 clk = ~clk;

  osmac_array #(.P(P), .KW(KW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .len_k(len_k),
    .step_valid(step_valid), .step_weight(step_weight), .step_act(step_act),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  // consumer back-pressure
  always begin
    @(negedge clk);
    #1;
    out_ready = hold_ready ? 1'b0 : (($urandom % 4) != 0);
  end

  // monitor / scoreboard
  logic pv = 0, pr = 0, ps = 0;
  logic [23:0] pd = '0;
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (pv && !pr && !ps)
        check(out_valid && out_data == pd, "R6", "hold under back-pressure",
              out_data, pd);
      if (out_valid && out_ready && !start) begin
        if (sb.size() == 0)
          check(0, "R7", "unexpected output", out_data, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(out_data == e.v, e.tag, "drained sum",
                longint'(out_data), longint'($signed(e.v)));
        end
      end
    end
    pv = out_valid; pr = out_ready; ps = start; pd = out_data;
  end

  task automatic do_start(int k);
    @(negedge clk);
    start = 1; len_k = KW'(k);
    @(negedge clk);
    start = 0;
  endtask

  // mode 0: random values, mode 1: all -128 (overflow)
  task automatic run_job(int k, int mode, bit gaps, bit abort, string tag);
    int w[$];
    int x[$];
    for (int t = 0; t < k; t++) begin
      if (mode == 1) begin w.push_back(-128); x.push_back(-128); end
      else begin
        w.push_back(int'($urandom % 256) - 128);
        x.push_back(int'($urandom % 256) - 128);
      end
    end
    sb.delete();
    for (int i = 0; i < P; i++) begin
      longint s;
      exp_t e;
      s = 0;
      for (int t = i; t < k; t++) s += longint'(w[t]) * longint'(x[t - i]);
      e.v = s[23:0];
      e.tag = tag;
      sb.push_back(e);
    end
    hold_ready = 1;
    do_start(k);
    if (k > 0) check(out_valid == 0, "R10", "valid low after start", out_valid, 0);
    for (int t = 0; t < k; t++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk);
        step_valid = 0; step_weight = 8'sd99; step_act = -8'sd77; // R4 junk
      end
      @(negedge clk);
      step_valid = 1; step_weight = w[t][7:0]; step_act = x[t][7:0];
      if (t == k - 1) check(done == 0, "R5", "done before last step", done, 0);
    end
    @(negedge clk);
    check(done == 1 && out_valid == 1, "R5", "done after K steps", done, 1);
    // R5: steps during drain are ignored
    step_valid = 1; step_weight = 8'sd127; step_act = 8'sd127;
    repeat (3) @(negedge clk);
    step_valid = 0;
    if (abort) return;
    hold_ready = 0;
    for (int n = 0; n < 2000 && sb.size() != 0; n++) @(negedge clk);
    @(posedge clk);
    #3;
    check(out_valid == 0 && done == 0, "R7", "idle after P outputs", out_valid, 0);
    check(sb.size() == 0, "R6", "all results delivered", sb.size(), 0);
    hold_ready = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(out_valid == 0 && done == 0, "R1", "reset state", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    #2;
    check(out_valid == 0 && done == 0, "R1", "idle after reset", done, 0);

    run_job(6, 0, 0, 0, "R3");
    run_job(9, 0, 1, 0, "R4");
    run_job(3, 0, 0, 0, "R3");
    run_job(600, 1, 0, 0, "R8");
    run_job(0, 0, 0, 0, "R9");
    run_job(5, 0, 0, 1, "R10");
    run_job(7, 0, 1, 0, "R2");
    run_job(12, 0, 1, 0, "R6");
    repeat (4) @(negedge clk);
    summary();
  end
endmodule